// File: doc/BRIEF.md
# Barrel Context Time-Slot Scheduler

This block shares one execution path among eight hardware thread contexts. Time is cut into a repeating frame of sixteen single-cycle slots, and a programmable slot map names the context that owns each slot. In an owned slot the scheduler presents that context's instruction to the shared datapath. Every instruction takes two owned slots: a first phase and a second phase. The context's program counter steps forward once the second phase completes.

The slot map can be rewritten at run time to change the share of cycles each context receives. Writes land in a shadow copy. That copy becomes the active map at the next frame boundary, so a frame never runs with a half-updated map. A per-context enable lets a context give up its slots: a slot owned by a disabled context is left idle, and the context's phase and program counter stay exactly as they were.

Top module: `barrel_slot_sched`

## Requirements
- R1: After reset the slot index is 0. Every context is in its first phase with program counter 0. Both map copies hold the equal share: slot s belongs to context s mod 8, so each context owns two slots per frame.
- R2: The slot index advances by one every cycle and wraps from 15 to 0. `frame_start` is high exactly when the slot index is 0.
- R3: `op_ctx` always equals the active-map entry for the current slot index.
- R4: A map write (`map_wr_en`, entry `map_wr_slot`, context `map_wr_ctx`) changes only the shadow map. The active map takes the whole shadow map on the clock edge that ends slot 15, and that includes a write made in that same cycle. The active map does not change at any other time.
- R5: `op_valid` is high when the owner of the current slot has its bit of `ctx_en` set. `op_phase` then shows that context's phase (0 = first, 1 = second), and each valid slot toggles that context's phase.
- R6: `op_retire` is high when `op_valid` is high and `op_phase` is 1. After such a slot the owner's program counter is one higher. `op_pc` shows the owner's program counter.
- R7: The phase and program counter of a context that does not hold the current valid slot keep their values. They can be read on `pc_flat`, where context c occupies bits [c*PC_W +: PC_W].
- R8: In a slot whose owner has its `ctx_en` bit at 0, `op_valid` and `op_retire` are low, and the owner's phase and program counter stay frozen. The context resumes where it stopped once the bit is set again.
- R9: A program counter wraps from 2^PC_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr_en | input | 1 | Write one shadow-map entry |
| map_wr_slot | input | SLOT_W | Slot entry to write |
| map_wr_ctx | input | CTX_W | Context to assign to that slot |
| ctx_en | input | NUM_CTX | Per-context enable |
| slot_idx | output | SLOT_W | Current slot index in the frame |
| frame_start | output | 1 | High in slot 0 |
| op_valid | output | 1 | Current slot issues or continues an instruction |
| op_ctx | output | CTX_W | Owner of the current slot |
| op_phase | output | 1 | Phase of the owner's instruction (0 first, 1 second) |
| op_retire | output | 1 | Current slot completes the owner's instruction |
| op_pc | output | PC_W | Program counter of the owner |
| pc_flat | output | NUM_CTX*PC_W | All program counters, context c at [c*PC_W +: PC_W] |

## Verification
The bench builds the block with eight contexts, sixteen slots and a 6-bit program counter. With that narrow counter, a context that owns every slot wraps its counter after 128 cycles, which puts the wrap case well within the run. Keeping the slot and context counts at their defaults means that random map writes with random entry and context values reach every slot entry, every owner, and writes that land exactly in slot 15. Random enable patterns catch contexts frozen part-way through an instruction, both in the first phase and in the second.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;
endpackage

// File: rtl/bsched_frame_ctr.sv
module bsched_frame_ctr #(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    if (slot_q == LAST) slot_d = '0;
    else                slot_d = slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot_o = slot_q;
  assign last_o = (slot_q == LAST);

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != LAST) |=> (slot_q == $past(slot_q) + SLOT_W'(1)));
  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == LAST) |=> (slot_q == '0));
endmodule

// File: rtl/bsched_slot_map.sv
module bsched_slot_map #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_CTX   = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CTX_W  = $clog2(NUM_CTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [CTX_W-1:0]  wr_ctx,
  input  logic              boundary_i,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [CTX_W-1:0]  rd_ctx
);
  logic [CTX_W-1:0] shadow_q [NUM_SLOTS];
  logic [CTX_W-1:0] shadow_d [NUM_SLOTS];
  logic [CTX_W-1:0] active_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_entry
    localparam logic [CTX_W-1:0] RST_CTX = CTX_W'(g % NUM_CTX);
    logic sh_we;

    assign sh_we = wr_en && (wr_slot == SLOT_W'(g));

    always_comb begin
      shadow_d[g] = shadow_q[g];
      if (sh_we) shadow_d[g] = wr_ctx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     shadow_q[g] <= RST_CTX;
      else if (sh_we) shadow_q[g] <= shadow_d[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          active_q[g] <= RST_CTX;
      else if (boundary_i) active_q[g] <= shadow_d[g];
    end

    // R4
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary_i |=> $stable(active_q[g]));
  end

  assign rd_ctx = active_q[rd_slot];
endmodule

// File: rtl/bsched_ctx_lane.sv
module bsched_ctx_lane
  import barrel_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant_i,
  output phase_e          phase_o,
  output logic [PC_W-1:0] pc_o
);
  phase_e          phase_q, phase_d;
  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    phase_d = (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
    pc_d    = (phase_q == PH_SECOND) ? pc_q + PC_W'(1) : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
      pc_q    <= '0;
    end else if (grant_i) begin
      phase_q <= phase_d;
      pc_q    <= pc_d;
    end
  end

  assign phase_o = phase_q;
  assign pc_o    = pc_q;

  // R7
  lane_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_i |=> ($stable(pc_q) && $stable(phase_q)));
  // R6
  lane_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_i && phase_q == PH_SECOND) |=> (pc_q == $past(pc_q) + PC_W'(1)));
  // R5
  lane_first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_i && phase_q == PH_FIRST) |=> ($stable(pc_q) && phase_q == PH_SECOND));
endmodule

// File: rtl/barrel_slot_sched.sv
module barrel_slot_sched
  import barrel_pkg::*;
#(
  parameter int NUM_CTX   = 8,
  parameter int NUM_SLOTS = 16,
  parameter int PC_W      = 16,
  localparam int CTX_W  = $clog2(NUM_CTX),
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    map_wr_en,
  input  logic [SLOT_W-1:0]       map_wr_slot,
  input  logic [CTX_W-1:0]        map_wr_ctx,
  input  logic [NUM_CTX-1:0]      ctx_en,
  output logic [SLOT_W-1:0]       slot_idx,
  output logic                    frame_start,
  output logic                    op_valid,
  output logic [CTX_W-1:0]        op_ctx,
  output logic                    op_phase,
  output logic                    op_retire,
  output logic [PC_W-1:0]         op_pc,
  output logic [NUM_CTX*PC_W-1:0] pc_flat
);
  logic [SLOT_W-1:0] slot_cur;
  logic              slot_last;
  logic [CTX_W-1:0]  owner;
  logic [NUM_CTX-1:0] grant;
  phase_e            phase_arr [NUM_CTX];
  logic [PC_W-1:0]   pc_arr    [NUM_CTX];

  bsched_frame_ctr #(.NUM_SLOTS(NUM_SLOTS)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .slot_o (slot_cur),
    .last_o (slot_last)
  );

  bsched_slot_map #(.NUM_SLOTS(NUM_SLOTS), .NUM_CTX(NUM_CTX)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (map_wr_en),
    .wr_slot    (map_wr_slot),
    .wr_ctx     (map_wr_ctx),
    .boundary_i (slot_last),
    .rd_slot    (slot_cur),
    .rd_ctx     (owner)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_lane
    assign grant[c] = ctx_en[c] && (owner == CTX_W'(c));

    bsched_ctx_lane #(.PC_W(PC_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant_i (grant[c]),
      .phase_o (phase_arr[c]),
      .pc_o    (pc_arr[c])
    );

    assign pc_flat[c*PC_W +: PC_W] = pc_arr[c];
  end

  always_comb begin
    slot_idx    = slot_cur;
    frame_start = (slot_cur == '0);
    op_ctx      = owner;
    op_valid    = ctx_en[owner];
    op_phase    = op_valid && (phase_arr[owner] == PH_SECOND);
    op_retire   = op_phase;
    op_pc       = pc_arr[owner];
  end

  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (grant == '0));
  // R6
  retire_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_retire |-> op_valid);
  // R6
  retire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_retire |=> (pc_arr[$past(owner)] == $past(op_pc) + PC_W'(1)));
endmodule

// File: tb/barrel_slot_sched_tb_top.sv
module barrel_slot_sched_tb_top;
  localparam int NC = 8;
  localparam int NS = 16;
  localparam int PW = 6;
  localparam int PCMOD = 1 << PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          map_wr_en = 1'b0;
  logic [3:0]    map_wr_slot = '0;
  logic [2:0]    map_wr_ctx = '0;
  logic [NC-1:0] ctx_en = '1;
  logic [3:0]    slot_idx;
  logic          frame_start, op_valid, op_phase, op_retire;
  logic [2:0]    op_ctx;
  logic [PW-1:0] op_pc;
  logic [NC*PW-1:0] pc_flat;

  int checks = 0;
  int failures = 0;
  int m_shadow [NS];
  int m_act [NS];
  int m_ph [NC];
  int m_pc [NC];
  int m_slot;
  bit done = 0;

  barrel_slot_sched #(.NUM_CTX(NC), .NUM_SLOTS(NS), .PC_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .map_wr_en(map_wr_en), .map_wr_slot(map_wr_slot),
    .map_wr_ctx(map_wr_ctx), .ctx_en(ctx_en), .slot_idx(slot_idx),
    .frame_start(frame_start), .op_valid(op_valid), .op_ctx(op_ctx),
    .op_phase(op_phase), .op_retire(op_retire), .op_pc(op_pc), .pc_flat(pc_flat)
  );

  always #2 clk = ~clk;

  function automatic int next_slot(int s);
    return (s + 1) % NS;
  endfunction

  function automatic int next_pc(int p);
    return (p + 1) % PCMOD;
  endfunction

  function automatic bit exp_retire(bit valid, int ph);
    return valid && (ph == 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin
      m_shadow[s] = s % NC;
      m_act[s] = s % NC;
    end
    for (int c = 0; c < NC; c++) begin
      m_ph[c] = 0;
      m_pc[c] = 0;
    end
    m_slot = 0;
  endtask

  task automatic check_all();
    int cur;
    bit v;
    cur = m_act[m_slot];
    v = ctx_en[cur];
    chk("R2 slot_idx", int'(slot_idx), m_slot);
    chk("R2 frame_start", int'(frame_start), int'(m_slot == 0));
    chk("R3 op_ctx", int'(op_ctx), cur);
    chk("R8 op_valid", int'(op_valid), int'(v));
    if (v) chk("R5 op_phase", int'(op_phase), m_ph[cur]);
    chk("R6 op_retire", int'(op_retire), int'(exp_retire(v, m_ph[cur])));
    chk("R6 op_pc", int'(op_pc), m_pc[cur]);
    for (int c = 0; c < NC; c++)
      chk("R7 pc_flat", int'(pc_flat[c*PW +: PW]), m_pc[c]);
  endtask

  // Check current outputs, drive new inputs, advance model, move to next negedge.
  task automatic step(bit we, int ws, int wc, logic [NC-1:0] en);
    int cur;
    check_all();
    map_wr_en = we;
    map_wr_slot = 4'(ws);
    map_wr_ctx = 3'(wc);
    ctx_en = en;
    cur = m_act[m_slot];
    if (en[cur]) begin
      if (m_ph[cur] == 1) m_pc[cur] = next_pc(m_pc[cur]);
      m_ph[cur] ^= 1;
    end
    if (we) m_shadow[ws] = wc;
    if (m_slot == NS - 1) m_act = m_shadow;
    m_slot = next_slot(m_slot);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0B17));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 slot_idx", int'(slot_idx), 0);
    chk("R1 op_ctx", int'(op_ctx), 0);
    chk("R1 op_phase", int'(op_phase), 0);
    chk("R1 pc_flat", int'(pc_flat), 0);

    // R1 equal share over one frame: slot s owned by context s mod 8
    for (int s = 0; s < NS; s++) begin
      chk("R1 equal share", int'(op_ctx), s % NC);
      step(0, 0, 0, '1);
    end

    // R4 write mid-frame: not visible this frame, visible next frame
    for (int s = 0; s < 3; s++) step(0, 0, 0, '1);
    step(1, 10, 5, '1);            // written while in slot 3
    for (int s = 4; s < 10; s++) step(0, 0, 0, '1);
    chk("R4 old owner in same frame", int'(op_ctx), 2);
    for (int s = 10; s < NS; s++) step(0, 0, 0, '1);
    for (int s = 0; s < 10; s++) step(0, 0, 0, '1);
    chk("R4 new owner next frame", int'(op_ctx), 5);
    // write exactly in slot 15 takes effect at slot 0
    for (int s = 10; s < NS - 1; s++) step(0, 0, 0, '1);
    step(1, 0, 6, '1);
    chk("R4 slot15 write applies", int'(op_ctx), 6);

    // R8 disable context 6 mid-instruction, state frozen while disabled
    begin
      int held;
      held = int'(pc_flat[6*PW +: PW]);
      for (int k = 0; k < 3 * NS; k++) step(0, 0, 0, 8'hBF);
      chk("R8 frozen pc ctx6", int'(pc_flat[6*PW +: PW]), held);
    end

    // R9 give every slot to context 2 and run it past the wrap
    for (int s = 0; s < NS; s++) step(1, s, 2, '1);
    for (int s = 0; s < NS; s++) step(0, 0, 0, '1);
    begin
      bit wrapped = 0;
      for (int k = 0; k < 3 * PCMOD && !wrapped; k++) begin
        if (m_pc[2] == PCMOD - 1 && m_ph[2] == 1) begin
          step(0, 0, 0, '1);
          chk("R9 pc wrap to 0", int'(pc_flat[2*PW +: PW]), 0);
          wrapped = 1;
        end else begin
          step(0, 0, 0, '1);
        end
      end
      chk("R9 wrap reached", int'(wrapped), 1);
    end

    // Random traffic
    for (int k = 0; k < 4000; k++) begin
      bit we;
      logic [NC-1:0] en;
      we = ($urandom % 4) == 0;
      en = 8'($urandom) | 8'($urandom);
      step(we, int'($urandom % NS), int'($urandom % NC), en);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule